// File: doc/BRIEF.md
# Transmit Buffer Descriptor Engine

This block moves outgoing frames from memory to a byte stream. It keeps a small ring of transmit descriptors in its own registers. Each descriptor takes two 32-bit words: a control/status word and a buffer pointer. The host fills descriptors through a word-addressed register port and gives each one to the engine by setting its ready bit.

The engine works through the ring strictly in order. For the current descriptor it reads the payload one 32-bit word at a time from a synchronous buffer memory port. It sends the bytes most-significant first on a valid/ready byte stream and marks the final byte as last. It then waits for a completion status from the MAC side. That status is written back into the low bits of the descriptor, the ready bit is cleared, and optional frame-sent and transmit-error interrupt pulses are raised.

The descriptor count must be a power of two.

Top module: `txbd_engine`

## Requirements
- R1: During and right after reset, `tx_valid`, `buf_rd_en`, `int_sent` and `int_err` are low, and every descriptor word reads back as zero.
- R2: The host writes descriptor word `host_addr` = {index, sel}, where sel 0 is the status word and sel 1 is the pointer word. `host_rdata` shows the addressed word one cycle after the address is applied.
- R3: Status bit 15 (ready) hands a descriptor to the engine. While the current descriptor is not ready, the engine issues no buffer reads. It checks that descriptor again after every host write.
- R4: Payload words are read at word address pointer[BUF_AW+1:2] plus 0, 1, 2 and so on, one read outstanding at a time. Read data is taken one cycle after `buf_rd_en`. Bytes are sent from bits 31:24 down to 7:0.
- R5: Status bits 31:16 give the frame length in bytes. Exactly that many bytes are sent, with `tx_last` on the final one. The engine issues ceil(length/4) reads, and bytes past the length in the last word are dropped.
- R6: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold steady.
- R7: After the final byte, the engine waits for `cmp_valid`. It then writes the 9-bit status into descriptor bits 8:0 and clears bit 15, leaving bits 31:16 and 14:9 unchanged. The status fields are: 8 underrun, 7:4 attempts, 3 retry limit, 2 late collision, 1 deferred, 0 carrier lost.
- R8: If status bit 14 (interrupt enable) is set, `int_sent` pulses for one cycle on the cycle after the completion is accepted. `int_err` pulses with it when underrun, retry limit or late collision is reported. Deferred and carrier lost alone raise no error. With bit 14 clear, neither pulse is raised.
- R9: Frames complete in ring order. After a descriptor with bit 13 (wrap) set, or after the last index, the engine goes to descriptor 0; otherwise it goes to the next index. A ready descriptor beyond a wrap point is not started.
- R10: A ready descriptor of length zero sends no bytes and issues no reads, but still waits for and records a completion status.
- R11: `cmp_valid` has no effect unless the engine is waiting for a completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Descriptor word write strobe |
| host_addr | input | IDX_W+1 | Descriptor word address {index, sel} |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Registered read data of the addressed word |
| buf_rd_en | output | 1 | Buffer memory read strobe |
| buf_addr | output | BUF_AW | Buffer memory word address |
| buf_rdata | input | 32 | Buffer read data, valid one cycle after the strobe |
| tx_data | output | 8 | Payload byte |
| tx_valid | output | 1 | Byte valid |
| tx_ready | input | 1 | Byte accepted by the sink |
| tx_last | output | 1 | Final byte of the frame |
| cmp_valid | input | 1 | Completion status strobe |
| cmp_status | input | 9 | Completion status fields |
| int_sent | output | 1 | Frame-sent interrupt pulse |
| int_err | output | 1 | Transmit-error interrupt pulse |

## Verification
The bench builds the engine with four descriptors and an 8-bit buffer word address. With that ring size, the forced return from the last index comes after only four frames, and a wrap flag on descriptor 0 can be shown to hold back an already-ready descriptor 1. The small buffer space lets the bench compute every payload word from its address. This makes misaligned lengths, zero length and sink back-pressure easy to cover in a short run.

// File: rtl/txbd_engine.sv
module txbd_engine #(
  parameter int NUM_DESC = 8,
  parameter int BUF_AW   = 16,
  localparam int IDX_W   = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [IDX_W:0]    host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              buf_rd_en,
  output logic [BUF_AW-1:0] buf_addr,
  input  logic [31:0]       buf_rdata,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic              tx_last,
  input  logic              cmp_valid,
  input  logic [8:0]        cmp_status,
  output logic              int_sent,
  output logic              int_err
);

  typedef enum logic [2:0] {S_POLL, S_RD, S_CAP, S_OUT, S_STAT} state_t;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_DESC - 1);

  state_t            state;
  logic [31:0]       st_mem  [NUM_DESC];
  logic [31:0]       ptr_mem [NUM_DESC];
  logic [IDX_W-1:0]  cur;
  logic              poll_pend;
  logic [15:0]       left;
  logic [BUF_AW-1:0] waddr;
  logic [31:0]       word;
  logic [1:0]        bsel;

  logic [31:0] cur_st;
  assign cur_st = st_mem[cur];

  assign buf_rd_en = (state == S_RD);
  assign buf_addr  = waddr;
  assign tx_valid  = (state == S_OUT);
  assign tx_data   = word[31:24];
  assign tx_last   = tx_valid && (left == 16'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_POLL;
      cur        <= '0;
      poll_pend  <= 1'b1;
      left       <= '0;
      waddr      <= '0;
      word       <= '0;
      bsel       <= '0;
      int_sent   <= 1'b0;
      int_err    <= 1'b0;
      host_rdata <= '0;
      for (int i = 0; i < NUM_DESC; i++) begin
        st_mem[i]  <= '0;
        ptr_mem[i] <= '0;
      end
    end else begin
      int_sent   <= 1'b0;
      int_err    <= 1'b0;
      host_rdata <= host_addr[0] ? ptr_mem[host_addr[IDX_W:1]] : st_mem[host_addr[IDX_W:1]];

      if (host_we) begin
        if (host_addr[0]) ptr_mem[host_addr[IDX_W:1]] <= host_wdata;
        else              st_mem[host_addr[IDX_W:1]]  <= host_wdata;
      end

      case (state)
        S_POLL: if (poll_pend) begin
          poll_pend <= 1'b0;
          if (cur_st[15]) begin
            left  <= cur_st[31:16];
            waddr <= ptr_mem[cur][BUF_AW+1:2];
            bsel  <= '0;
            state <= (cur_st[31:16] == 16'd0) ? S_STAT : S_RD;
          end
        end
        S_RD:  state <= S_CAP;
        S_CAP: begin
          word  <= buf_rdata;
          state <= S_OUT;
        end
        S_OUT: if (tx_ready) begin
          left <= left - 16'd1;
          word <= word << 8;
          bsel <= bsel + 2'd1;
          if (left == 16'd1) state <= S_STAT;
          else if (bsel == 2'd3) begin
            waddr <= waddr + 1'b1;
            state <= S_RD;
          end
        end
        S_STAT: if (cmp_valid) begin
          st_mem[cur] <= {cur_st[31:16], 1'b0, cur_st[14:9], cmp_status};
          int_sent    <= cur_st[14];
          int_err     <= cur_st[14] & (cmp_status[8] | cmp_status[3] | cmp_status[2]);
          cur         <= (cur_st[13] || cur == LAST_IDX) ? '0 : cur + 1'b1;
          poll_pend   <= 1'b1;
          state       <= S_POLL;
        end
        default: state <= S_POLL;
      endcase

      if (host_we) poll_pend <= 1'b1;
    end
  end

endmodule

// File: rtl/txbd_engine_chk.sv
module txbd_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] tx_data,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       tx_last,
  input logic       buf_rd_en,
  input logic       cmp_valid,
  input logic       int_sent,
  input logic       int_err
);

  p_last_in_beat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);

  p_hold_on_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

  p_one_read_outstanding_r4: assert property (@(posedge clk) disable iff (!rst_n)
    buf_rd_en |=> !buf_rd_en && !tx_valid);

  p_err_with_sent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    int_err |-> int_sent);

  p_sent_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    int_sent |=> !int_sent);

  p_sent_after_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
    int_sent |-> $past(cmp_valid));

endmodule

bind txbd_engine txbd_engine_chk u_chk (.*);

// File: tb/txbd_engine_tb_top.sv
`timescale 1ns/1ps
module txbd_engine_tb_top;
  localparam int ND = 4;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_we = 1'b0;
  logic [2:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic buf_rd_en;
  logic [AW-1:0] buf_addr;
  logic [31:0] buf_rdata = '0;
  logic [7:0] tx_data;
  logic tx_valid, tx_last, int_sent, int_err;
  logic tx_ready = 1'b1;
  logic cmp_valid = 1'b0;
  logic [8:0] cmp_status = '0;

  int checks = 0, errors = 0;
  int rd_cnt = 0, byte_cnt = 0, sent_cnt = 0, err_cnt = 0, cyc = 0;
  bit stall = 1'b0;
  logic [8:0] exp_q[$];

  always #2 clk = ~clk;

  txbd_engine #(.NUM_DESC(ND), .BUF_AW(AW)) dut_i (.*);

  function automatic logic [31:0] memf(input logic [7:0] a);
    return {a, ~a, a ^ 8'h5A, a + 8'd3};
  endfunction

  always @(posedge clk) begin
    if (buf_rd_en) begin
      buf_rdata <= memf(buf_addr);
      rd_cnt++;
    end
    cyc++;
    #1 tx_ready = stall ? (cyc % 3 != 2) : 1'b1;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (int_sent) sent_cnt++;
    if (int_err) err_cnt++;
    if (tx_valid && tx_ready) begin
      byte_cnt++;
      if (exp_q.size() == 0) check(1'b0, "R5 unexpected byte", {23'd0, tx_last, tx_data}, 32'h0);
      else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        check({tx_last, tx_data} == e, "R4/R5 byte", {23'd0, tx_last, tx_data}, {23'd0, e});
      end
    end
  end

  task automatic host_write(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(posedge clk); #1;
    host_we = 1'b0;
  endtask

  task automatic host_read(input logic [2:0] a, output logic [31:0] d);
    @(posedge clk); #1 host_addr = a;
    @(posedge clk); @(negedge clk);
    d = host_rdata;
  endtask

  task automatic expect_frame(input logic [31:0] ptr, input int len);
    for (int i = 0; i < len; i++) begin
      logic [31:0] w;
      w = memf(8'((ptr >> 2) + i / 4));
      exp_q.push_back({(i == len - 1), w[31 - 8 * (i % 4) -: 8]});
    end
  endtask

  task automatic setup_desc(input int idx, input int len, input logic [31:0] ptr, input logic [15:0] flags);
    host_write(3'(idx * 2 + 1), ptr);
    host_write(3'(idx * 2), {16'(len), flags});
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic complete(input logic [8:0] st);
    @(posedge clk); #1 cmp_valid = 1'b1; cmp_status = st;
    @(posedge clk); #1 cmp_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic frame(input string req, input int idx, input int len, input logic [31:0] ptr,
                       input logic [15:0] flags, input logic [8:0] st,
                       input int e_sent, input int e_err, input logic [31:0] e_rb);
    int r0, b0, s0, x0;
    logic [31:0] rb;
    r0 = rd_cnt; b0 = byte_cnt;
    expect_frame(ptr, len);
    setup_desc(idx, len, ptr, flags);
    drain();
    check(rd_cnt - r0 == (len + 3) / 4, {req, " R5 read count"}, rd_cnt - r0, (len + 3) / 4);
    check(byte_cnt - b0 == len, {req, " R5 byte count"}, byte_cnt - b0, len);
    s0 = sent_cnt; x0 = err_cnt;
    complete(st);
    check(sent_cnt - s0 == e_sent, {req, " R8 sent pulse"}, sent_cnt - s0, e_sent);
    check(err_cnt - x0 == e_err, {req, " R8 error pulse"}, err_cnt - x0, e_err);
    host_read(3'(idx * 2), rb);
    check(rb == e_rb, {req, " R7 written-back status"}, rb, e_rb);
  endtask

  initial begin
    #(4 * 100000);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rb;
    int r0, s0, b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(!tx_valid && !buf_rd_en && !int_sent && !int_err, "R1 outputs idle",
          {tx_valid, buf_rd_en, int_sent, int_err}, 0);
    host_read(3'd1, rb);
    check(rb == 0, "R1 descriptor cleared", rb, 0);
    host_write(3'd7, 32'h1234_5678);
    host_read(3'd7, rb);
    check(rb == 32'h1234_5678, "R2 pointer word access", rb, 32'h1234_5678);
    r0 = rd_cnt;
    repeat (10) @(negedge clk);
    check(rd_cnt == r0, "R3 no reads while not ready", rd_cnt - r0, 0);

    frame("T1", 0, 5, 32'h40, 16'hC000, 9'h010, 1, 0, 32'h0005_4010);
    stall = 1'b1;
    frame("T2 stall", 1, 8, 32'h100, 16'hC000, 9'h100, 1, 1, 32'h0008_4100);
    stall = 1'b0;
    frame("T3 R10 zero length", 2, 0, 32'h80, 16'hC000, 9'h003, 1, 0, 32'h0000_4003);
    frame("T4 no irq", 3, 3, 32'h20, 16'h9E00, 9'h00C, 0, 0, 32'h0003_1E0C);

    s0 = sent_cnt;
    @(posedge clk); #1 cmp_valid = 1'b1; cmp_status = 9'h1FF;
    @(posedge clk); #1 cmp_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(sent_cnt == s0, "R11 stray status no pulse", sent_cnt - s0, 0);
    host_read(3'd6, rb);
    check(rb == 32'h0003_1E0C, "R11 stray status no write", rb, 32'h0003_1E0C);

    r0 = rd_cnt;
    setup_desc(1, 4, 32'hC0, 16'hC000);
    repeat (20) @(negedge clk);
    check(rd_cnt == r0, "R9 ring returned to 0, R3 idle", rd_cnt - r0, 0);

    stall = 1'b1;
    frame("T6 wrap", 0, 6, 32'h10, 16'hE000, 9'h020, 1, 0, 32'h0006_6020);
    stall = 1'b0;
    r0 = rd_cnt;
    repeat (20) @(negedge clk);
    check(rd_cnt == r0, "R9 wrap holds back next", rd_cnt - r0, 0);
    host_read(3'd2, rb);
    check(rb == 32'h0004_C000, "R9 desc1 still ready", rb, 32'h0004_C000);

    expect_frame(32'h200, 2);
    setup_desc(0, 2, 32'h200, 16'hC000);
    drain();
    b0 = byte_cnt;
    expect_frame(32'hC0, 4);
    complete(9'h010);
    drain();
    check(byte_cnt - b0 == 4, "R9 next descriptor follows in order", byte_cnt - b0, 4);
    complete(9'h030);
    host_read(3'd2, rb);
    check(rb == 32'h0004_4030, "R7 desc1 written back", rb, 32'h0004_4030);
    host_read(3'd0, rb);
    check(rb == 32'h0002_4010, "R7 desc0 written back", rb, 32'h0002_4010);
    check(exp_q.size() == 0, "R5 all bytes seen", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule